// File: doc/BRIEF.md
# Single-Request Interrupt Mapping Controller

This block collects 64 level-sensitive interrupt lines and offers the processor at most one vector request at a time. Lines 0 to 31 come from bus slots. They are grouped four to a map register, so eight shared registers govern them. Lines 32 to 63 are on-board sources, and each has a map register of its own. Bit 31 of a map register enables its lines. Bits 30:0 hold fixed routing constants that software can read but not change.

A request, once latched, stays outstanding until software drops it. Software can do this in two ways: by writing a clear register, or by writing the owning map register with its enable bit at zero. While no request is held, the block picks the lowest-numbered line that is both asserted and enabled, and registers it on the next clock edge. A rising, enabled bus-slot line pre-empts a held request at once. An on-board line waits until the controller is idle.

A simple register bus reaches the map and clear registers. Reads return data one cycle after the read strobe.

Top module: `irq_map_ctrl`

## Requirements
- R1: The byte address selects a register as follows. Bits [10:8] give the region: 0 bus-slot map, 1 on-board map, 2 error map, 3 bus-slot clear, 4 on-board clear. Bits [7:3] give the index, and bit 2 must be 1. Read data appears on `bus_rdata` the cycle after `bus_rd`. A map register reads {enable, low bits}. The low bits are 0x7C0 | (g<<2) for bus-slot group g and 0x7E0 + k for on-board line k. Error map registers 0 and 1 read the constant 0x7F0.
- R2: A map write changes only bit 31 (the enable). Bits 30:0 keep their constants. A held request always belongs to a line whose map enable is set.
- R3: With no request held, the lowest-numbered line that is asserted and enabled becomes the request at the next clock edge. Bus-slot line i uses group i/4, and line 32+k uses on-board register k.
- R4: A bus-slot line that rises while its group is enabled becomes the request at the next edge, even if another request is held. When several such lines rise together, the lowest-numbered one wins.
- R5: An on-board line that asserts while a request is held does not displace that request.
- R6: Writing a map register with the enable at 0 drops the held request if the request's line belongs to that register. The rescan at the same edge then selects the next request using the updated enables.
- R7: A write to bus-slot clear register k drops a held request r < 32 when r/4 = k. A write to on-board clear register k drops a held request equal to 32+k. Either write rescans at the same edge.
- R8: A synchronous reset clears every enable bit and the stored line history. It sets `req_vec` to the no-request code 65, with `req_valid` low.
- R9: The even 32-bit word of each 8-byte slot reads as zero and ignores writes. Clear registers read as zero.
- R10: When a line deasserts, a request already held for it is not withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level interrupt lines; 0-31 bus slots, 32-63 on-board |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | A request is outstanding |
| req_vec | output | 7 | Outstanding line number, 65 when none |

## Verification
The hardest case is a drop and a rescan landing on the same edge while several other lines are still asserted. Only then does it show whether the rescan sees the enables as they stand after the write. The stimulus builds up a backlog for this: disabled bus-slot lines, an on-board line that asserts while a request is held, and a line that deasserts while it is the request. It then drops requests by clear writes and by map writes that turn the enable off, and it checks which line wins each rescan. A separate sequence asserts two on-board lines while they are disabled and enables them one at a time. This confirms that a held request is not displaced and that the lower-numbered line wins the rescan that follows the clear.

// File: rtl/imc_pkg.sv
package imc_pkg;

  localparam logic [2:0] RG_SLOT_MAP = 3'd0;
  localparam logic [2:0] RG_OB_MAP   = 3'd1;
  localparam logic [2:0] RG_ERR_MAP  = 3'd2;
  localparam logic [2:0] RG_SLOT_CLR = 3'd3;
  localparam logic [2:0] RG_OB_CLR   = 3'd4;

  localparam int          N_ERR_MAP   = 2;
  localparam logic [31:0] ERR_MAP_VAL = 32'h0000_07F0;

  typedef struct packed {
    logic       slot_map_wr;
    logic       ob_map_wr;
    logic       slot_clr;
    logic       ob_clr;
    logic [4:0] idx;
    logic       en_bit;
  } bus_evt_t;

  function automatic logic [30:0] slot_map_low(input int g);
    return 31'(32'h7C0 | (g << 2));
  endfunction

  function automatic logic [30:0] ob_map_low(input int k);
    return 31'(32'h7E0 + k);
  endfunction

endpackage

// File: rtl/imc_prio_enc.sv
module imc_prio_enc #(
  parameter int W     = 64,
  parameter int OUT_W = 6
) (
  input  logic [W-1:0]     vec,
  output logic             found,
  output logic [OUT_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = OUT_W'(i);
      end
    end
  end
endmodule

// File: rtl/imc_regfile.sv
module imc_regfile
  import imc_pkg::*;
#(
  parameter int N_GRP  = 8,
  parameter int N_OB   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_GRP-1:0]  slot_en_q,
  output logic [N_OB-1:0]   ob_en_q,
  output logic [N_GRP-1:0]  slot_en_nx,
  output logic [N_OB-1:0]   ob_en_nx,
  output bus_evt_t          evt
);
  localparam int GRP_IW = (N_GRP > 1) ? $clog2(N_GRP) : 1;
  localparam int OB_IW  = (N_OB > 1) ? $clog2(N_OB) : 1;

  logic [2:0] region;
  logic [4:0] idx;
  logic       odd;
  logic       slot_ok, ob_ok, err_ok;
  logic       wr_odd;
  logic [31:0] rd_nx;
  logic       addr_unused;

  assign region = bus_addr[10:8];
  assign idx    = bus_addr[7:3];
  assign odd    = bus_addr[2];
  assign slot_ok = ({1'b0, idx} < 6'(N_GRP));
  assign ob_ok   = ({1'b0, idx} < 6'(N_OB));
  assign err_ok  = ({1'b0, idx} < 6'(N_ERR_MAP));
  assign wr_odd  = bus_wr && odd;
  assign addr_unused = ^{bus_addr[ADDR_W-1:11], bus_addr[1:0], bus_wdata[30:0]};

  // decoded write events
  always_comb begin
    evt             = '0;
    evt.idx         = idx;
    evt.en_bit      = bus_wdata[31];
    evt.slot_map_wr = wr_odd && (region == RG_SLOT_MAP) && slot_ok;
    evt.ob_map_wr   = wr_odd && (region == RG_OB_MAP) && ob_ok;
    evt.slot_clr    = wr_odd && (region == RG_SLOT_CLR) && slot_ok;
    evt.ob_clr      = wr_odd && (region == RG_OB_CLR) && ob_ok;
  end

  // next enables: only bit 31 of a map register is writable
  always_comb begin
    slot_en_nx = slot_en_q;
    ob_en_nx   = ob_en_q;
    for (int g = 0; g < N_GRP; g++)
      if (evt.slot_map_wr && (idx == 5'(g))) slot_en_nx[g] = evt.en_bit;
    for (int k = 0; k < N_OB; k++)
      if (evt.ob_map_wr && (idx == 5'(k))) ob_en_nx[k] = evt.en_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_en_q <= '0;
      ob_en_q   <= '0;
    end else begin
      slot_en_q <= slot_en_nx;
      ob_en_q   <= ob_en_nx;
    end
  end

  // read mux
  always_comb begin
    rd_nx = '0;
    if (odd) begin
      case (region)
        RG_SLOT_MAP: if (slot_ok) rd_nx = {slot_en_q[idx[GRP_IW-1:0]], slot_map_low(int'(idx))};
        RG_OB_MAP:   if (ob_ok)   rd_nx = {ob_en_q[idx[OB_IW-1:0]], ob_map_low(int'(idx))};
        RG_ERR_MAP:  if (err_ok)  rd_nx = ERR_MAP_VAL;
        default:     rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nx;
  end

  AST_EVEN_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr[2]) |=> (bus_rdata == 32'd0)); // R9

  AST_SLOT_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (evt.slot_map_wr && !evt.en_bit && (idx == 5'd0)) |=> !slot_en_q[0]); // R2

endmodule

// File: rtl/imc_req_ctrl.sv
module imc_req_ctrl
  import imc_pkg::*;
#(
  parameter int N_GRP  = 8,
  parameter int GRP_SZ = 4,
  parameter int N_OB   = 32,
  parameter int VEC_W  = 7
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_GRP*GRP_SZ+N_OB-1:0]  irq_in,
  input  logic [N_GRP-1:0]              slot_en_q,
  input  logic [N_OB-1:0]               ob_en_q,
  input  logic [N_GRP-1:0]              slot_en_nx,
  input  logic [N_OB-1:0]               ob_en_nx,
  input  bus_evt_t                      evt,
  output logic                          req_valid,
  output logic [VEC_W-1:0]              req_vec
);
  localparam int N_SLOT  = N_GRP * GRP_SZ;
  localparam int N_LINES = N_SLOT + N_OB;
  localparam int LW      = $clog2(N_LINES);
  localparam int SW      = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam logic [VEC_W-1:0] NO_REQ = VEC_W'(N_LINES + 1);

  logic [N_LINES-1:0] line_en_q, line_en_nx;
  logic [N_SLOT-1:0]  slot_seen_q, slot_rise;
  logic [N_LINES-1:0] masked;
  logic               rise_found, scan_found, drop;
  logic [SW-1:0]      rise_idx;
  logic [LW-1:0]      scan_idx;
  logic [VEC_W-1:0]   req_nx;

  // per-line enable fan-out
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot_en
    assign line_en_q[i]  = slot_en_q[i / GRP_SZ];
    assign line_en_nx[i] = slot_en_nx[i / GRP_SZ];
  end
  for (genvar k = 0; k < N_OB; k++) begin : g_ob_en
    assign line_en_q[N_SLOT + k]  = ob_en_q[k];
    assign line_en_nx[N_SLOT + k] = ob_en_nx[k];
  end

  always_ff @(posedge clk) begin
    if (rst) slot_seen_q <= '0;
    else     slot_seen_q <= irq_in[N_SLOT-1:0];
  end

  assign masked    = irq_in & line_en_nx;
  assign slot_rise = irq_in[N_SLOT-1:0] & ~slot_seen_q & line_en_nx[N_SLOT-1:0];

  imc_prio_enc #(.W(N_SLOT), .OUT_W(SW)) u_rise_enc (
    .vec(slot_rise), .found(rise_found), .idx(rise_idx));

  imc_prio_enc #(.W(N_LINES), .OUT_W(LW)) u_scan_enc (
    .vec(masked), .found(scan_found), .idx(scan_idx));

  // drop decision for the held request
  always_comb begin
    int  cur;
    int  ix;
    logic is_slot;
    cur     = int'(req_vec);
    ix      = int'(evt.idx);
    is_slot = req_valid && (cur < N_SLOT);
    drop    = 1'b0;
    if ((evt.slot_map_wr && !evt.en_bit) || evt.slot_clr)
      if (is_slot && ((cur / GRP_SZ) == ix)) drop = 1'b1;
    if ((evt.ob_map_wr && !evt.en_bit) || evt.ob_clr)
      if (req_valid && !is_slot && ((cur - N_SLOT) == ix)) drop = 1'b1;
  end

  always_comb begin
    req_nx = req_vec;
    if (drop) req_nx = NO_REQ;
    if (rise_found)
      req_nx = VEC_W'(rise_idx);
    else if ((req_nx == NO_REQ) && scan_found)
      req_nx = VEC_W'(scan_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_vec   <= NO_REQ;
      req_valid <= 1'b0;
    end else begin
      req_vec   <= req_nx;
      req_valid <= (req_nx != NO_REQ);
    end
  end

  AST_RESET_NOREQ: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!req_valid && (req_vec == NO_REQ))); // R8

  AST_HELD_ENABLED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> line_en_q[req_vec[LW-1:0]]); // R2

  AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && (|(irq_in & line_en_nx))) |=> req_valid); // R3

  AST_SLOT_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (|slot_rise) |=> (req_valid && (int'(req_vec) < N_SLOT))); // R4

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !evt.slot_map_wr && !evt.ob_map_wr && !evt.slot_clr && !evt.ob_clr
     && !(|slot_rise)) |=> $stable(req_vec)); // R10

endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl
  import imc_pkg::*;
#(
  parameter int N_GRP  = 8,
  parameter int GRP_SZ = 4,
  parameter int N_OB   = 32,
  parameter int ADDR_W = 12,
  localparam int N_LINES = N_GRP * GRP_SZ + N_OB,
  localparam int VEC_W   = $clog2(N_LINES + 2)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               req_valid,
  output logic [VEC_W-1:0]   req_vec
);
  logic [N_GRP-1:0] slot_en_q, slot_en_nx;
  logic [N_OB-1:0]  ob_en_q, ob_en_nx;
  bus_evt_t         evt;

  imc_regfile #(.N_GRP(N_GRP), .N_OB(N_OB), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slot_en_q(slot_en_q), .ob_en_q(ob_en_q),
    .slot_en_nx(slot_en_nx), .ob_en_nx(ob_en_nx), .evt(evt));

  imc_req_ctrl #(.N_GRP(N_GRP), .GRP_SZ(GRP_SZ), .N_OB(N_OB), .VEC_W(VEC_W)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .slot_en_q(slot_en_q), .ob_en_q(ob_en_q),
    .slot_en_nx(slot_en_nx), .ob_en_nx(ob_en_nx), .evt(evt),
    .req_valid(req_valid), .req_vec(req_vec));

endmodule

// File: tb/sim_irq_map_ctrl.sv
module sim_irq_map_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq = '0;
  logic        bwr = 1'b0, brd = 1'b0;
  logic [11:0] baddr = '0;
  logic [31:0] bwd = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [6:0]  rvec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    int          kind;   // 0 request, 1 read data
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  exp_t it;

  irq_map_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq), .bus_wr(bwr), .bus_rd(brd),
    .bus_addr(baddr), .bus_wdata(bwd), .bus_rdata(rdata),
    .req_valid(rvalid), .req_vec(rvec));

  always #(CLK_PERIOD / 2) clk = ~clk;

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_tests++;
      if (it.kind == 0) begin
        if (rvec !== it.exp[6:0] || rvalid !== (it.exp < 64)) begin
          n_fail++;
          $display("FAIL %s: req actual=%0d/%0b expected=%0d/%0b",
                   it.tag, rvec, rvalid, it.exp, it.exp < 64);
        end
      end else if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int kind, input logic [31:0] e, input string tag);
    exp_t x;
    x.kind = kind; x.exp = e; x.tag = tag;
    sb_q.push_back(x);
  endtask

  task automatic expect_req(input int v, input string tag);
    push(0, 32'(v), tag);
    step();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bwr = 1'b1; baddr = a; bwd = d;
    step();
    bwr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    brd = 1'b1; baddr = a;
    step();
    brd = 1'b0;
    push(1, e, tag);
    step();
  endtask

  task automatic set_irq(input int line, input logic lvl);
    irq[line] = lvl;
    step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    expect_req(65, "R8 reset no request");
    rd(12'h01C, 32'h0000_07CC, "R1 slot group 3 map");
    rd(12'h12C, 32'h0000_07E5, "R1 on-board 5 map");
    rd(12'h20C, 32'h0000_07F0, "R1 error map 1");
    rd(12'h018, 32'h0, "R9 even word reads zero");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h8000_07C4, "R2 only enable bit written");
    wr(12'h010, 32'h8000_0000);
    rd(12'h014, 32'h0000_07C8, "R9 even word write ignored");
    set_irq(6, 1'b1);
    expect_req(6, "R4 enabled slot rise taken");
    set_irq(9, 1'b1);
    expect_req(6, "R3 disabled group not taken");
    wr(12'h01C, 32'h8000_0000);
    expect_req(6, "R6 enable write keeps request");
    set_irq(13, 1'b1);
    expect_req(13, "R4 slot rise preempts");
    wr(12'h114, 32'h8000_0000);
    set_irq(34, 1'b1);
    expect_req(13, "R5 on-board waits while busy");
    set_irq(13, 1'b0);
    expect_req(13, "R10 deassert keeps request");
    wr(12'h31C, 32'h0);
    expect_req(6, "R7 slot clear 3 drops, rescan lowest");
    wr(12'h304, 32'h0);
    expect_req(6, "R7 slot clear other group no effect");
    wr(12'h308, 32'h0);
    expect_req(6, "R9 even clear word ignored");
    rd(12'h31C, 32'h0, "R9 clear register reads zero");
    wr(12'h00C, 32'h0);
    expect_req(34, "R6 map disable drops, rescan new enables");
    wr(12'h40C, 32'h0);
    expect_req(34, "R7 on-board clear other index no effect");
    set_irq(34, 1'b0);
    expect_req(34, "R10 on-board deassert keeps request");
    wr(12'h414, 32'h0);
    expect_req(65, "R7 on-board clear drops to idle");
    irq[35] = 1'b1; irq[40] = 1'b1;
    step();
    expect_req(65, "R3 disabled on-board lines ignored");
    wr(12'h144, 32'h8000_0000);
    expect_req(40, "R3 enable write rescans");
    wr(12'h11C, 32'h8000_0000);
    expect_req(40, "R5 held request not displaced");
    wr(12'h444, 32'h0);
    expect_req(35, "R3 lowest index wins rescan");
    rst = 1'b1;
    step();
    rst = 1'b0;
    expect_req(65, "R8 mid-run reset");
    rd(12'h11C, 32'h0000_07E3, "R8 reset clears enable");
    expect_req(65, "R8 asserted lines stay unmapped");
    repeat (3) step();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule